// File: doc/BRIEF.md
# Dual-Thread Instruction Queue with Compare-Branch Fusion

The block buffers pre-decoded instruction records for two hardware threads. Each thread has its own queue, so one thread's records can never be reordered with, blocked by or merged into the other thread's records. Every record carries a thread id, a two-bit class tag and a payload. The class tag is the only opcode information the block uses.

At the output, a round-robin selector picks one thread per cycle. If the head of that thread's queue is a compare/test and the next entry in the same queue is a conditional branch, the two entries leave together as a single record with the fused flag set. The record carries both payloads and uses one output slot. A compare that sits alone at the head of its queue is held for one cycle to give its branch a chance to arrive. After that cycle it issues unfused.

Each queue has its own full and empty flags and its own flush input. Downstream back-pressure is applied with a ready input.

Top module: `dual_iq_fuse`

## Requirements
- R1: After reset both queues are empty (`empty_o` all ones, `full_o` all zeros) and `out_valid_o` is low.
- R2: The records of one thread leave in the order they were written. A record that is not fused leaves with `out_fused_o` low and carries its own class and payload.
- R3: Each queue holds `DEPTH` entries (default 25, 50 in total). A write to a full thread is dropped and has no effect on the other thread.
- R4: When the head of the selected thread has class 1 (compare/test) and the next entry of the same thread has class 2 (conditional branch), one record leaves. That record has `out_fused_o` high, the compare payload on `out_data_o`, the branch payload on `out_data2_o` and class 1 on `out_cls_o`.
- R5: A compare followed by class 0 (plain) or class 3 (unconditional branch) is not fused. A compare and a branch in different threads are not fused either.
- R6: At most one record, and so at most one fusion, leaves per cycle. A fused record removes exactly two entries from its queue.
- R7: A compare that is the only entry of its queue is held for exactly one cycle. In the next cycle it issues unfused, unless a conditional branch has arrived behind it, in which case the pair fuses.
- R8: A flush pulse on `flush_i[t]` empties queue t in the next cycle. It leaves the other queue untouched.
- R9: When both threads have eligible records, the output alternates between them. Thread 0 is served first after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Write strobe for an incoming record |
| in_tid_i | input | $clog2(NTHR) | Thread of the incoming record |
| in_cls_i | input | 2 | Class: 0 plain, 1 compare/test, 2 conditional branch, 3 unconditional branch |
| in_data_i | input | DATA_W | Incoming payload |
| flush_i | input | NTHR | Per-thread flush |
| full_o | output | NTHR | Per-thread full flag |
| empty_o | output | NTHR | Per-thread empty flag |
| out_ready_i | input | 1 | Downstream accepts the output record |
| out_valid_o | output | 1 | Output record valid |
| out_tid_o | output | $clog2(NTHR) | Thread of the output record |
| out_fused_o | output | 1 | Record is a fused compare-and-branch |
| out_cls_o | output | 2 | Class of the (first) instruction |
| out_data_o | output | DATA_W | Payload of the (first) instruction |
| out_data2_o | output | DATA_W | Branch payload when fused, zero otherwise |

## Verification
A sweep runs all 64 three-record class sequences in thread 0, each paired with a mirrored sequence in thread 1. The queues are preloaded and then drained. Comparing each thread's output with a pairing computed in the bench separates correct fusion from fusion across threads, fusion with a plain record or an unconditional branch, and reordering.

Directed patterns cover the remaining behaviour:
- Filling a queue to its limit and writing again shows that the extra write is dropped and the other thread is unaffected.
- Flushing one loaded queue shows that the flush is confined to that thread.
- A lone compare, and a compare whose branch arrives one cycle later, show the exact length of the one-cycle hold.
- Balanced loads in both threads show the alternation order.

// File: rtl/iq_fuse_pkg.sv
package iq_fuse_pkg;
  typedef enum logic [1:0] {
    CLS_PLAIN = 2'd0,
    CLS_CMP   = 2'd1,
    CLS_CBR   = 2'd2,
    CLS_UBR   = 2'd3
  } cls_e;
endpackage

// File: rtl/iq_thread_fifo.sv
module iq_thread_fifo #(
  parameter int DEPTH  = 25,
  parameter int DATA_W = 16,
  localparam int PW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_cls_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              pop_one_i,
  input  logic              pop_two_i,
  output logic [CW-1:0]     cnt_o,
  output logic [1:0]        h0_cls_o,
  output logic [DATA_W-1:0] h0_data_o,
  output logic [1:0]        h1_cls_o,
  output logic [DATA_W-1:0] h1_data_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam int EW = DATA_W + 2;

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          wr_ok;
  logic [CW-1:0] npop;

  function automatic logic [PW-1:0] adv(input logic [PW-1:0] p, input int n);
    int s;
    s = int'(p) + n;
    if (s >= DEPTH) s = s - DEPTH;
    return PW'(s);
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign wr_ok   = wr_en_i && !full_o && !flush_i;
  assign npop    = pop_two_i ? CW'(2) : (pop_one_i ? CW'(1) : CW'(0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_ok) wr_q <= adv(wr_q, 1);
      if (pop_two_i)      rd_q <= adv(rd_q, 2);
      else if (pop_one_i) rd_q <= adv(rd_q, 1);
      cnt_q <= cnt_q + CW'(wr_ok) - npop;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem[wr_q] <= {wr_cls_i, wr_data_i};
  end

  logic [EW-1:0] e0, e1;
  assign e0        = mem[rd_q];
  assign e1        = mem[adv(rd_q, 1)];
  assign h0_cls_o  = e0[EW-1 -: 2];
  assign h0_data_o = e0[DATA_W-1:0];
  assign h1_cls_o  = e1[EW-1 -: 2];
  assign h1_data_o = e1[DATA_W-1:0];
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/iq_fuse_sel.sv
module iq_fuse_sel
  import iq_fuse_pkg::*;
#(
  parameter int NTHR = 2,
  parameter int CW   = 5,
  localparam int TW  = $clog2(NTHR)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NTHR-1:0][CW-1:0]  cnt_i,
  input  logic [NTHR-1:0][1:0]     h0_cls_i,
  input  logic [NTHR-1:0][1:0]     h1_cls_i,
  input  logic [NTHR-1:0]          flush_i,
  input  logic                     ready_i,
  output logic                     valid_o,
  output logic [TW-1:0]            tid_o,
  output logic                     fuse_o,
  output logic [NTHR-1:0]          pop_one_o,
  output logic [NTHR-1:0]          pop_two_o
);
  logic [TW-1:0]   last_q;
  logic [NTHR-1:0] wait_q, wait_d, lone, elig, pair_ok;

  always_comb begin
    for (int t = 0; t < NTHR; t++) begin
      lone[t]    = (cnt_i[t] == CW'(1)) && (h0_cls_i[t] == CLS_CMP);
      pair_ok[t] = (cnt_i[t] >= CW'(2)) && (h0_cls_i[t] == CLS_CMP) && (h1_cls_i[t] == CLS_CBR);
      // a lone compare sits out one cycle waiting for its branch
      elig[t]    = (cnt_i[t] != '0) && !flush_i[t] && !(lone[t] && !wait_q[t]);
    end
  end

  always_comb begin
    valid_o = 1'b0;
    tid_o   = '0;
    for (int k = 1; k <= NTHR; k++) begin
      int idx;
      idx = (int'(last_q) + k) % NTHR;
      if (!valid_o && elig[idx]) begin
        valid_o = 1'b1;
        tid_o   = TW'(idx);
      end
    end
    fuse_o = valid_o && pair_ok[tid_o];
  end

  always_comb begin
    for (int t = 0; t < NTHR; t++) begin
      pop_one_o[t] = valid_o && ready_i && !fuse_o && (tid_o == TW'(t));
      pop_two_o[t] = valid_o && ready_i &&  fuse_o && (tid_o == TW'(t));
      wait_d[t]    = lone[t] && !flush_i[t] && !pop_one_o[t] && !pop_two_o[t];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= TW'(NTHR - 1);
      wait_q <= '0;
    end else begin
      wait_q <= wait_d;
      if (valid_o && ready_i) last_q <= tid_o;
    end
  end
endmodule

// File: rtl/dual_iq_fuse.sv
module dual_iq_fuse #(
  parameter int NTHR   = 2,
  parameter int DEPTH  = 25,
  parameter int DATA_W = 16,
  localparam int TW    = $clog2(NTHR),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [TW-1:0]     in_tid_i,
  input  logic [1:0]        in_cls_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic [NTHR-1:0]   flush_i,
  output logic [NTHR-1:0]   full_o,
  output logic [NTHR-1:0]   empty_o,
  input  logic              out_ready_i,
  output logic              out_valid_o,
  output logic [TW-1:0]     out_tid_o,
  output logic              out_fused_o,
  output logic [1:0]        out_cls_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic [DATA_W-1:0] out_data2_o
);
  logic [NTHR-1:0][CW-1:0]     cnt_w;
  logic [NTHR-1:0][1:0]        h0_cls_w, h1_cls_w;
  logic [NTHR-1:0][DATA_W-1:0] h0_data_w, h1_data_w;
  logic [NTHR-1:0]             pop_one_w, pop_two_w;
  logic                        sel_valid, sel_fuse;
  logic [TW-1:0]               sel_tid;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    iq_thread_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_fifo (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .flush_i   (flush_i[t]),
      .wr_en_i   (in_valid_i && (in_tid_i == TW'(t))),
      .wr_cls_i  (in_cls_i),
      .wr_data_i (in_data_i),
      .pop_one_i (pop_one_w[t]),
      .pop_two_i (pop_two_w[t]),
      .cnt_o     (cnt_w[t]),
      .h0_cls_o  (h0_cls_w[t]),
      .h0_data_o (h0_data_w[t]),
      .h1_cls_o  (h1_cls_w[t]),
      .h1_data_o (h1_data_w[t]),
      .full_o    (full_o[t]),
      .empty_o   (empty_o[t])
    );
  end

  iq_fuse_sel #(.NTHR(NTHR), .CW(CW)) i_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_i     (cnt_w),
    .h0_cls_i  (h0_cls_w),
    .h1_cls_i  (h1_cls_w),
    .flush_i   (flush_i),
    .ready_i   (out_ready_i),
    .valid_o   (sel_valid),
    .tid_o     (sel_tid),
    .fuse_o    (sel_fuse),
    .pop_one_o (pop_one_w),
    .pop_two_o (pop_two_w)
  );

  assign out_valid_o = sel_valid;
  assign out_tid_o   = sel_tid;
  assign out_fused_o = sel_fuse;
  assign out_cls_o   = sel_valid ? h0_cls_w[sel_tid]  : 2'd0;
  assign out_data_o  = sel_valid ? h0_data_w[sel_tid] : '0;
  assign out_data2_o = sel_fuse  ? h1_data_w[sel_tid] : '0;
endmodule

// File: rtl/iq_fuse_chk.sv
module iq_fuse_chk #(
  parameter int NTHR  = 2,
  parameter int DEPTH = 25,
  localparam int TW   = $clog2(NTHR),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    in_valid_i,
  input logic [TW-1:0]           in_tid_i,
  input logic [NTHR-1:0]         flush_i,
  input logic [NTHR-1:0]         full_o,
  input logic [NTHR-1:0]         empty_o,
  input logic                    out_valid_o,
  input logic                    out_ready_i,
  input logic [TW-1:0]           out_tid_o,
  input logic [NTHR-1:0][CW-1:0] cnt_w,
  input logic [NTHR-1:0]         pop_two_w
);
  assert_valid_nonempty_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !empty_o[out_tid_o]);

  for (genvar t = 0; t < NTHR; t++) begin : g_chk
    assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_w[t] <= CW'(DEPTH));

    assert_full_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (full_o[t] && !flush_i[t] && !(out_valid_o && out_ready_i && out_tid_o == TW'(t)))
      |=> full_o[t]);

    assert_fused_pops_two_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pop_two_w[t] && !flush_i[t] && !(in_valid_i && in_tid_i == TW'(t)))
      |=> cnt_w[t] == $past(cnt_w[t]) - CW'(2));

    assert_flush_empties_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_i[t] |=> empty_o[t]);
  end
endmodule

bind dual_iq_fuse iq_fuse_chk #(.NTHR(NTHR), .DEPTH(DEPTH)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_tid_i    (in_tid_i),
  .flush_i     (flush_i),
  .full_o      (full_o),
  .empty_o     (empty_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_tid_o   (out_tid_o),
  .cnt_w       (cnt_w),
  .pop_two_w   (pop_two_w)
);

// File: tb/test_dual_iq_fuse.sv
`timescale 1ns/1ps
module test_dual_iq_fuse;
  localparam int DEPTH = 25;
  localparam int DW    = 16;

  typedef struct {
    bit f;
    int c;
    int d0;
    int d1;
  } rec_t;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          in_valid = 0;
  logic [0:0]    in_tid = 0;
  logic [1:0]    in_cls = 0;
  logic [DW-1:0] in_data = 0;
  logic [1:0]    flush = 0;
  logic [1:0]    full, empty;
  logic          ready = 0;
  logic          o_valid, o_fused;
  logic [0:0]    o_tid;
  logic [1:0]    o_cls;
  logic [DW-1:0] o_d0, o_d1;

  int   nchk = 0, nfail = 0;
  rec_t got [2][$];
  rec_t expq[2][$];
  int   ord [$];

  always #4 clk = ~clk;

  dual_iq_fuse #(.NTHR(2), .DEPTH(DEPTH), .DATA_W(DW)) i_dual_iq_fuse (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_tid_i(in_tid),
    .in_cls_i(in_cls), .in_data_i(in_data), .flush_i(flush), .full_o(full),
    .empty_o(empty), .out_ready_i(ready), .out_valid_o(o_valid), .out_tid_o(o_tid),
    .out_fused_o(o_fused), .out_cls_o(o_cls), .out_data_o(o_d0), .out_data2_o(o_d1)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge
  task automatic push(input int t, input int c, input int d);
    in_valid = 1; in_tid = 1'(t); in_cls = 2'(c); in_data = DW'(d);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic clear_got();
    got[0].delete(); got[1].delete(); ord.delete();
  endtask

  task automatic drain();
    ready = 1;
    for (int i = 0; i < 200; i++) begin
      if (o_valid) begin
        rec_t r;
        r.f = o_fused; r.c = int'(o_cls); r.d0 = int'(o_d0); r.d1 = int'(o_d1);
        got[o_tid].push_back(r);
        ord.push_back(int'(o_tid));
      end else if (empty == 2'b11) begin
        break;
      end
      @(negedge clk);
    end
    ready = 0;
  endtask

  task automatic build_exp(input int t, input int cls[3], input int dat[3]);
    int i;
    expq[t].delete();
    i = 0;
    while (i < 3) begin
      rec_t r;
      r.c = cls[i]; r.d0 = dat[i];
      if (cls[i] == 1 && i < 2 && cls[i+1] == 2) begin
        r.f = 1; r.d1 = dat[i+1]; i += 2;
      end else begin
        r.f = 0; r.d1 = 0; i += 1;
      end
      expq[t].push_back(r);
    end
  endtask

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk(empty == 2'b11, "R1 empty", int'(empty), 3);
    chk(full == 2'b00, "R1 full", int'(full), 0);
    chk(!o_valid, "R1 valid", int'(o_valid), 0);

    // R9 alternation starting with thread 0
    push(0, 0, 10); push(0, 0, 11); push(1, 0, 20); push(1, 0, 21);
    clear_got(); drain();
    chk(ord.size() == 4, "R9 count", ord.size(), 4);
    for (int i = 0; i < 4 && i < ord.size(); i++)
      chk(ord[i] == (i % 2), "R9 order", ord[i], i % 2);

    // R2 R4 R5 sweep over all three-record class sequences
    for (int s = 0; s < 64; s++) begin
      int c0[3], c1[3], d0[3], d1[3];
      bit ok;
      for (int i = 0; i < 3; i++) begin
        c0[i] = (s >> (2 * i)) & 3;
        c1[i] = ((63 - s) >> (2 * (2 - i))) & 3;
        d0[i] = s * 16 + i;
        d1[i] = 4096 + s * 16 + i;
      end
      for (int i = 0; i < 3; i++) begin
        push(0, c0[i], d0[i]);
        push(1, c1[i], d1[i]);
      end
      build_exp(0, c0, d0);
      build_exp(1, c1, d1);
      clear_got(); drain();
      for (int t = 0; t < 2; t++) begin
        ok = (got[t].size() == expq[t].size());
        for (int i = 0; ok && i < expq[t].size(); i++)
          ok = (got[t][i].f == expq[t][i].f) && (got[t][i].c == expq[t][i].c) &&
               (got[t][i].d0 == expq[t][i].d0) && (got[t][i].d1 == expq[t][i].d1);
        chk(ok, "R2/R4/R5 sweep (R2 R4 R5)", got[t].size(), expq[t].size());
      end
    end

    // R3 full thread refuses, other thread unaffected
    for (int i = 0; i < DEPTH; i++) push(0, 0, i);
    chk(full == 2'b01, "R3 full flags", int'(full), 1);
    push(0, 0, 999);
    push(1, 0, 777);
    chk(full[0] == 1'b1, "R3 still full", int'(full[0]), 1);
    chk(empty[1] == 1'b0, "R3 other accepted", int'(empty[1]), 0);
    clear_got(); drain();
    chk(got[0].size() == DEPTH, "R3 depth", got[0].size(), DEPTH);
    if (got[0].size() == DEPTH)
      chk(got[0][DEPTH-1].d0 == DEPTH - 1, "R3 refused dropped", got[0][DEPTH-1].d0, DEPTH - 1);
    chk(got[1].size() == 1, "R3 other count", got[1].size(), 1);
    if (got[1].size() == 1) chk(got[1][0].d0 == 777, "R3 other data", got[1][0].d0, 777);

    // R8 flush one thread only
    push(0, 0, 1); push(0, 1, 2); push(0, 2, 3); push(1, 0, 5); push(1, 0, 6);
    flush = 2'b01;
    @(negedge clk);
    flush = 2'b00;
    chk(empty == 2'b01, "R8 empty flags", int'(empty), 1);
    clear_got(); drain();
    chk(got[0].size() == 0, "R8 flushed thread", got[0].size(), 0);
    chk(got[1].size() == 2, "R8 other thread", got[1].size(), 2);

    // R7 lone compare held exactly one cycle
    ready = 1;
    push(0, 1, 300);
    chk(!o_valid, "R7 held", int'(o_valid), 0);
    @(negedge clk);
    chk(o_valid && !o_fused && o_d0 == DW'(300), "R7 issue unfused", int'(o_d0), 300);
    @(negedge clk);
    chk(empty == 2'b11 && !o_valid, "R7 consumed", int'(empty), 3);

    // R7 R4 R6 branch arriving during the hold fuses into one record
    push(1, 1, 400);
    push(1, 2, 401);
    chk(o_valid && o_fused && o_tid == 1'b1, "R7 late fuse", int'(o_fused), 1);
    chk(o_d0 == DW'(400) && o_d1 == DW'(401), "R4 fused payloads", int'(o_d1), 401);
    @(negedge clk);
    chk(empty == 2'b11 && !o_valid, "R6 pair removed in one slot", int'(empty), 3);
    ready = 0;

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule